// File: doc/BRIEF.md
# Asynchronous Parallel FIFO Slave Port

This block lets an external host move bytes through an 8-bit shared data bus using two strobes and two status flags. Inside the chip it connects to two byte streams. The transmit stream fills a small queue that the host empties one byte per read strobe. Each host write strobe fills a receive queue, and that queue drains into the receive stream. Both queues are part of the block.

The host strobes arrive with no relation to the system clock. Each one passes through a multi-flop synchronizer before any edge is acted on. The read strobe is active low. The write strobe is active high, and a byte is taken when it falls. After each strobe the matching status flag is held inactive for a recovery window. That window is a cycle count derived from a time in nanoseconds and the clock period.

A read while nothing is queued, or a write while the receive queue is full, changes no data. Either one sets a violation flag that stays set until reset. The bus is modelled as a data-out vector plus an output enable.

Top module: `fifop_port`

## Requirements
- R1: After reset, rxf_n is 1, txe_n is 0, d_oe is 0, proto_err is 0, rx_valid is 0 and tx_ready is 1.
- R2: rxf_n is 0 when the transmit queue holds at least one byte and no read recovery window is running. rxf_n is 1 whenever the transmit queue is empty.
- R3: d_oe is 1 exactly while rd_n is 0, and it follows rd_n without waiting for a clock edge.
- R4: Each synchronized falling edge of rd_n removes the oldest byte from the transmit queue and places it on d_out, where it stays until the next accepted read. Bytes leave in the order they entered.
- R5: Once a rising edge of rd_n has been synchronized, rxf_n is 1 for exactly HOLD_CYC consecutive cycles. HOLD_CYC is RECOVER_NS divided by CLK_PERIOD_NS, rounded up, which is 4 at the defaults.
- R6: Each synchronized falling edge of wr takes the value that d_in had while wr was last sampled high. That byte goes into the receive queue and is later delivered on rx_data/rx_valid in order.
- R7: Once a falling edge of wr has been synchronized, txe_n is 1 for exactly HOLD_CYC consecutive cycles.
- R8: txe_n is 1 while the receive queue is full.
- R9: A read strobe while the transmit queue is empty removes nothing, leaves d_out unchanged and sets proto_err.
- R10: A write strobe while the receive queue is full stores nothing, so the byte is never delivered, and it sets proto_err.
- R11: tx_ready is 0 while the transmit queue holds TXQ_DEPTH bytes.
- R12: Once set, proto_err stays 1 until rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr | input | 1 | Host write strobe, active high, byte taken on its fall |
| d_in | input | DATA_W | Bus value seen from the pads |
| d_out | output | DATA_W | Byte driven towards the pads during a read |
| d_oe | output | 1 | Pad output enable |
| rxf_n | output | 1 | Low when the host may read |
| txe_n | output | 1 | Low when the host may write |
| tx_data | input | DATA_W | Byte to be offered to the host |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| rx_data | output | DATA_W | Byte written by the host |
| rx_valid | output | 1 | rx_data is valid |
| rx_ready | input | 1 | Consumer takes rx_data |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest case to reach is a write strobe that arrives while the receive queue is full, because the consumer normally drains that queue as soon as it fills. The bench holds rx_ready low and issues exactly as many writes as the queue holds, then issues one more. It then releases the consumer and shows that only the queued bytes appear and that the violation flag has latched. The recovery windows are measured by counting consecutive high samples of each flag after the strobe edge. An empty-queue read is provoked right after a second reset, so that the flag can be seen going from clear to set.

// File: rtl/fifop_pkg.sv
package fifop_pkg;
   localparam int MIN_SYNC_STAGES = 2;

   // Round a time in ns up to whole clock cycles.
   function automatic int cycles_for(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction
endpackage

// File: rtl/fifop_sync.sv
module fifop_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_BIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < fifop_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("fifop_sync: STAGES below minimum");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{{W{RST_BIT}}}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fifop_queue.sv
module fifop_queue #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   generate
      if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("fifop_queue: DEPTH must be a power of two");
      end

      if (DEPTH == 1) begin : g_single
         logic         held;
         logic [W-1:0] slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    held <= 1'b0;
            else if (push) held <= 1'b1;
            else if (pop)  held <= 1'b0;
         end
         always_ff @(posedge clk) begin
            if (push) slot <= wdata;
         end
         assign rdata = slot;
         assign full  = held;
         assign empty = !held;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         logic [AW:0]  wp, rp;
         logic [W-1:0] mem [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (push) wp <= wp + 1'b1;
               if (pop)  rp <= rp + 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (push) mem[wp[AW-1:0]] <= wdata;
         end
         assign rdata = mem[rp[AW-1:0]];
         assign empty = (wp == rp);
         assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
      end
   endgenerate
endmodule

// File: rtl/fifop_holdoff.sv
module fifop_holdoff #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYC + 1);
   logic [CW-1:0] cnt;

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("fifop_holdoff: CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(CYC);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/fifop_port.sv
module fifop_port #(
   parameter int DATA_W        = 8,
   parameter int TXQ_DEPTH     = 4,
   parameter int RXQ_DEPTH     = 4,
   parameter int CLK_PERIOD_NS = 20,
   parameter int RECOVER_NS    = 80,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out,
   output logic              d_oe,
   output logic              rxf_n,
   output logic              txe_n,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic              proto_err
);
   localparam int HOLD_CYC = fifop_pkg::cycles_for(RECOVER_NS, CLK_PERIOD_NS);

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("fifop_port: CLK_PERIOD_NS must be positive");
      end
      if (SYNC_STAGES < fifop_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
         $error("fifop_port: SYNC_STAGES too small");
      end
   endgenerate

   // Strobe and data synchronizers
   logic              rd_q, rd_qp, wr_q, wr_qp;
   logic [DATA_W-1:0] d_cap;

   fifop_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .d(rd_n), .q(rd_q));
   fifop_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .d(wr), .q(wr_q));
   // One stage deeper so the byte lines up with the last high sample of wr
   fifop_sync #(.W(DATA_W), .STAGES(SYNC_STAGES + 1), .RST_BIT(1'b0)) u_d_sync (
      .clk(clk), .rst_n(rst_n), .d(d_in), .q(d_cap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_qp <= 1'b1;
         wr_qp <= 1'b0;
      end else begin
         rd_qp <= rd_q;
         wr_qp <= wr_q;
      end
   end

   logic rd_fall_evt, rd_rise_evt, wr_fall_evt;
   assign rd_fall_evt = rd_qp & ~rd_q;
   assign rd_rise_evt = ~rd_qp & rd_q;
   assign wr_fall_evt = wr_qp & ~wr_q;

   // Transmit side: internal stream -> host reads
   logic              txq_full, txq_empty, txq_pop;
   logic [DATA_W-1:0] txq_head, dout_q;

   assign tx_ready = ~txq_full;
   assign txq_pop  = rd_fall_evt & ~txq_empty;

   fifop_queue #(.W(DATA_W), .DEPTH(TXQ_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_valid & ~txq_full), .wdata(tx_data),
      .pop(txq_pop), .rdata(txq_head),
      .full(txq_full), .empty(txq_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (txq_pop) dout_q <= txq_head;
   end

   assign d_out = dout_q;
   assign d_oe  = ~rd_n;

   // Receive side: host writes -> internal stream
   logic rxq_full, rxq_empty;

   fifop_queue #(.W(DATA_W), .DEPTH(RXQ_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_fall_evt & ~rxq_full), .wdata(d_cap),
      .pop(rx_valid & rx_ready), .rdata(rx_data),
      .full(rxq_full), .empty(rxq_empty));

   assign rx_valid = ~rxq_empty;

   // Recovery windows on the status flags
   logic rd_busy, wr_busy;

   fifop_holdoff #(.CYC(HOLD_CYC)) u_rd_hold (
      .clk(clk), .rst_n(rst_n), .start(rd_rise_evt), .busy(rd_busy));
   fifop_holdoff #(.CYC(HOLD_CYC)) u_wr_hold (
      .clk(clk), .rst_n(rst_n), .start(wr_fall_evt), .busy(wr_busy));

   assign rxf_n = txq_empty | rd_busy;
   assign txe_n = rxq_full  | wr_busy;

   // Sticky violation flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) proto_err <= 1'b0;
      else if ((rd_fall_evt & txq_empty) | (wr_fall_evt & rxq_full))
         proto_err <= 1'b1;
   end
endmodule

// File: rtl/fifop_port_chk.sv
module fifop_port_chk #(
   parameter int HOLD_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic rd_n,
   input logic d_oe,
   input logic rxf_n,
   input logic txe_n,
   input logic proto_err,
   input logic rd_rise_evt,
   input logic rd_fall_evt,
   input logic wr_fall_evt,
   input logic txq_empty,
   input logic rxq_full
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   logic [CW-1:0] rd_win, wr_win;

   // Independent window counters for the recovery checks
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_win <= '0;
         wr_win <= '0;
      end else begin
         if (rd_rise_evt)        rd_win <= CW'(HOLD_CYC);
         else if (rd_win != '0)  rd_win <= rd_win - 1'b1;
         if (wr_fall_evt)        wr_win <= CW'(HOLD_CYC);
         else if (wr_win != '0)  wr_win <= wr_win - 1'b1;
      end
   end

   a_r2_rxf_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      txq_empty |-> rxf_n);
   a_r3_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> !d_oe);
   a_r5_rxf_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_win != '0) |-> rxf_n);
   a_r7_txe_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_win != '0) |-> txe_n);
   a_r8_txe_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_full |-> txe_n);
   a_r9_err_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall_evt && txq_empty) |=> proto_err);
   a_r10_err_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fall_evt && rxq_full) |=> proto_err);
   a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
endmodule

bind fifop_port fifop_port_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .d_oe(d_oe),
   .rxf_n(rxf_n), .txe_n(txe_n), .proto_err(proto_err),
   .rd_rise_evt(rd_rise_evt), .rd_fall_evt(rd_fall_evt),
   .wr_fall_evt(wr_fall_evt), .txq_empty(txq_empty), .rxq_full(rxq_full));

// File: tb/fifop_port_tb.sv
`timescale 1ns/1ps
module fifop_port_tb;
   localparam int DW   = 8;
   localparam int TXD  = 4;
   localparam int RXD  = 4;
   localparam int HOLD = 4;

   logic          clk = 1'b0;
   logic          rst_n, rd_n, wr, tx_valid, rx_ready;
   logic [DW-1:0] d_in, tx_data;
   logic [DW-1:0] d_out, rx_data;
   logic          d_oe, rxf_n, txe_n, tx_ready, rx_valid, proto_err;

   int n_chk  = 0;
   int n_fail = 0;
   logic [DW-1:0] exp_tx[$];
   logic [DW-1:0] exp_rx[$];
   logic [DW-1:0] last_rd;

   always #10 clk = ~clk;

   fifop_port u_dut (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr(wr), .d_in(d_in),
      .d_out(d_out), .d_oe(d_oe), .rxf_n(rxf_n), .txe_n(txe_n),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .proto_err(proto_err));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      last_rd = '0;
   endtask

   // Driver: offer one byte on the transmit stream
   task automatic tx_push(input logic [DW-1:0] b, output bit took);
      @(negedge clk);
      tx_data = b; tx_valid = 1'b1;
      #1 took = tx_ready;
      if (took) exp_tx.push_back(b);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   // Count consecutive cycles a flag stays high after a strobe edge
   task automatic measure_hold(input bit use_rxf, output int n);
      for (int i = 0; i < 6 && !(use_rxf ? rxf_n : txe_n); i++) @(negedge clk);
      n = 0;
      while ((use_rxf ? rxf_n : txe_n) && n < 20) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic host_read(input bit ok, input bit chk_hold);
      logic [DW-1:0] e;
      int n;
      @(negedge clk); rd_n = 1'b0;
      #1 check("R3 oe on", d_oe, 1'b1);
      repeat (4) @(negedge clk);
      if (ok) begin
         e = exp_tx.pop_front();
         check("R4 read byte", d_out, e);
         last_rd = e;
      end else begin
         check("R9 d_out unchanged", d_out, last_rd);
      end
      rd_n = 1'b1;
      #1 check("R3 oe off", d_oe, 1'b0);
      if (chk_hold) begin
         measure_hold(1'b1, n);
         check("R5 rxf recovery", n, HOLD);
      end else begin
         repeat (HOLD + 4) @(negedge clk);
      end
   endtask

   task automatic host_write(input logic [DW-1:0] b, input bit accepted, input bit chk_hold);
      int n;
      @(negedge clk); d_in = b;
      @(negedge clk); wr = 1'b1;
      repeat (3) @(negedge clk);
      wr = 1'b0;
      if (accepted) exp_rx.push_back(b);
      if (chk_hold) begin
         measure_hold(1'b0, n);
         check("R7 txe recovery", n, HOLD);
      end else begin
         repeat (HOLD + 4) @(negedge clk);
      end
   endtask

   // Monitor: compare every byte leaving the receive stream
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && rx_valid && rx_ready) begin
            if (exp_rx.size() == 0) begin
               check("R6 unexpected rx byte", rx_data, 32'hFFFF_FFFF);
            end else begin
               check("R6 rx byte", rx_data, exp_rx.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      bit took;
      rst_n = 1'b0; rd_n = 1'b1; wr = 1'b0; d_in = '0;
      tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b1;
      do_reset();

      // R1 reset state
      check("R1 rxf_n", rxf_n, 1'b1);
      check("R1 txe_n", txe_n, 1'b0);
      check("R1 d_oe", d_oe, 1'b0);
      check("R1 proto_err", proto_err, 1'b0);
      check("R1 rx_valid", rx_valid, 1'b0);
      check("R1 tx_ready", tx_ready, 1'b1);

      // R2 / R4 / R5 reads
      tx_push(8'hA5, took); tx_push(8'h3C, took); tx_push(8'h81, took);
      repeat (2) @(negedge clk);
      check("R2 rxf_n low with data", rxf_n, 1'b0);
      host_read(1'b1, 1'b1);
      host_read(1'b1, 1'b1);
      host_read(1'b1, 1'b0);
      check("R2 rxf_n high when empty", rxf_n, 1'b1);

      // R11 transmit queue full
      for (int i = 0; i < TXD; i++) begin
         tx_push(8'h10 + 8'(i), took);
         check("R11 push accepted", took, 1'b1);
      end
      tx_push(8'hFF, took);
      check("R11 tx_ready low when full", took, 1'b0);
      for (int i = 0; i < TXD; i++) host_read(1'b1, 1'b0);

      // R6 / R7 writes
      host_write(8'h5A, 1'b1, 1'b1);
      host_write(8'hC3, 1'b1, 1'b1);
      host_write(8'h0F, 1'b1, 1'b0);
      check("R6 all bytes delivered", exp_rx.size(), 0);
      check("R10 no error yet", proto_err, 1'b0);

      // R8 / R10 receive queue full
      rx_ready = 1'b0;
      for (int i = 0; i < RXD; i++) host_write(8'h21 + 8'(i), 1'b1, 1'b0);
      check("R8 txe_n high when full", txe_n, 1'b1);
      host_write(8'hEE, 1'b0, 1'b0);
      check("R10 error on full write", proto_err, 1'b1);
      check("R8 txe_n still high", txe_n, 1'b1);
      @(negedge clk); rx_ready = 1'b1;
      repeat (10) @(negedge clk);
      check("R10 extra byte dropped", rx_valid, 1'b0);
      check("R10 queued bytes delivered", exp_rx.size(), 0);
      check("R12 error still set", proto_err, 1'b1);

      // R12 cleared only by reset, R9 empty read
      do_reset();
      check("R12 error cleared by reset", proto_err, 1'b0);
      host_read(1'b0, 1'b0);
      check("R9 error on empty read", proto_err, 1'b1);
      check("R9 rxf_n still high", rxf_n, 1'b1);
      tx_push(8'h77, took);
      repeat (2) @(negedge clk);
      host_read(1'b1, 1'b0);
      check("R12 error sticky after good read", proto_err, 1'b1);

      report();
      $finish;
   end
endmodule